// File: doc/BRIEF.md
# BCD Calendar Counter with Century

This block keeps wall-clock time as eight packed-BCD fields: seconds, minutes, hours (24-hour), day of week, date, month, two-digit year and century. A free-running prescaler counts pulses of a tick-enable input, which is normally a 32.768 kHz enable. Each full prescaler period yields one one-second advance, and that advance ripples through the fields with the right carries. Date carries respect the length of the current month, and February gets a 29th day in every year whose two BCD digits form a multiple of four.

Software sets the time with a single-cycle parallel load of all eight fields. The load also zeroes the prescaler, so the first advance after a load comes one full second later. A stop input freezes the prescaler and every field. A frequency-test input makes the least significant bit of the seconds output toggle at 1/64 of the tick rate (512 Hz at 32.768 kHz) while the clock runs, which gives a quick way to measure the prescaler. All controls are plain level or pulse pins. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the outputs read 00:00:00, day 01, date 01, month 01, year 00, century 20 (all BCD), and the prescaler is zero.
- R2: Seconds advance by one after every PRESC_DIV accepted tick-enable pulses. A pulse is accepted when tick_en is 1, stop_osc is 0 and load_en is 0. The new value appears on the outputs in the cycle after the accepted pulse that completes the period. Gaps in tick_en only delay the advance.
- R3: Seconds and minutes count 00..59. Hours count 00..23. Each wraps to 00 and carries into the next field: seconds into minutes, minutes into hours, and hours into both day of week and date.
- R4: Day of week counts 01..07 and returns from 07 to 01 on the midnight carry.
- R5: The date returns to 01 and carries into the month after day 30 in months 04, 06, 09 and 11, and after day 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R6: In month 02 the date wraps after 29 when the year is a multiple of four (00, 04, ..., 96), and after 28 otherwise.
- R7: The month wraps from 12 to 01 and increments the year. The year wraps from 99 to 00 and increments the century. The century wraps from 39 to 00.
- R8: A one-cycle load_en writes all eight fields from ld_time in the next cycle and clears the prescaler. The field layout in ld_time is: [7:0] seconds, [15:8] minutes, [23:16] hours, [31:24] day of week, [39:32] date, [47:40] month, [55:48] year, [63:56] century. The load takes priority over counting and works while stopped.
- R9: While stop_osc is 1 the tick_en input is ignored: the prescaler and all fields hold.
- R10: While freq_test is 1 and stop_osc is 0, sec_o[0] equals the seconds LSB XOR bit log2(PRESC_DIV)-10 of the prescaler. At the default this toggles at 512 Hz. Otherwise sec_o[0] is the true seconds LSB. Bits 7:1 of sec_o are never affected.
- R11: A field loaded above its maximum (for example date 31 in month 04) returns to its minimum on its next increment and carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler count enable (32.768 kHz rate nominal) |
| stop_osc | input | 1 | Freezes prescaler and all fields |
| freq_test | input | 1 | Enables the seconds-LSB test toggle |
| load_en | input | 1 | One-cycle parallel load strobe |
| ld_time | input | 64 | Packed BCD load value, layout in R8 |
| sec_o | output | 8 | Seconds, BCD 00..59 (bit 0 may carry test toggle) |
| min_o | output | 8 | Minutes, BCD 00..59 |
| hour_o | output | 8 | Hours, BCD 00..23 |
| dow_o | output | 8 | Day of week, BCD 01..07 |
| date_o | output | 8 | Date, BCD 01..31 |
| month_o | output | 8 | Month, BCD 01..12 |
| year_o | output | 8 | Year, BCD 00..99 |
| cent_o | output | 8 | Century, BCD 00..39 |

## Verification
Every cycle, the assertions check these properties: a load lands in the next cycle, a field that sees no increment and no load holds, a field at or above its limit returns to its minimum on an increment, the prescaler freezes under stop, and the seconds LSB is untouched when test mode is off. Other properties need the bench's scenarios, run against its behavioural calendar model. These are the month-length and leap-year decisions, the full midnight-to-new-century ripple, the exact cycle of the first advance after reset or a load, and the 512 Hz toggle phase.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int NUM_FIELDS = 8;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  // Next BCD value; anything at or above the limit returns to the minimum.
  function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
    if (v >= hi)
      return lo;
    else if (v[3:0] >= 4'd9)
      return {v[7:4] + 4'd1, 4'd0};
    else
      return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Two-digit BCD year divisible by four.
  function automatic logic year_is_leap(input logic [7:0] yr);
    if (yr[4])
      return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else
      return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic halt,
  input  logic restart,
  output logic sec_pulse,
  output logic test_phase
);
  localparam int CW   = $clog2(DIV);
  localparam int TBIT = CW - 10;

  logic [CW-1:0] count;

  assign sec_pulse  = tick_en && !halt && !restart && (count == CW'(DIV - 1));
  assign test_phase = count[TBIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (restart)
      count <= '0;
    else if (tick_en && !halt)
      count <= count + 1'b1;
  end

  // R9
  halt_freezes_prescaler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !restart) |=> $stable(count));

  // R8
  restart_clears_prescaler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));

  // R2
  pulse_wraps_prescaler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> (count == '0));

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] last_date
);
  always_comb begin
    unique case (month)
      8'h02:                      last_date = cal_pkg::year_is_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
  parameter logic [7:0] LO  = 8'h00,
  parameter logic [7:0] RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic [7:0] hi,
  output logic [7:0] val,
  output logic       carry
);
  assign carry = inc && (val >= hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      val <= RST;
    else if (load)
      val <= load_val;
    else if (inc)
      val <= cal_pkg::bcd_next(val, LO, hi);
  end

  // R8
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (val == $past(load_val)));

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(val));

  // R11
  limit_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (val >= hi)) |=> (val == LO));

endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter #(
  parameter int PRESC_DIV = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        stop_osc,
  input  logic        freq_test,
  input  logic        load_en,
  input  logic [63:0] ld_time,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o,
  output logic [7:0]  hour_o,
  output logic [7:0]  dow_o,
  output logic [7:0]  date_o,
  output logic [7:0]  month_o,
  output logic [7:0]  year_o,
  output logic [7:0]  cent_o
);
  import cal_pkg::*;

  localparam int NF = NUM_FIELDS;
  // Per-field minimum and reset values, field i in bits [8*i +: 8].
  localparam logic [8*NF-1:0] FIELD_LO  = {8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam logic [8*NF-1:0] FIELD_RST = {8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic          sec_pulse;
  logic          test_phase;
  logic [7:0]    fval  [NF];
  logic [7:0]    fhi   [NF];
  logic [NF-1:0] finc;
  logic [NF-1:0] fcarry;
  logic [7:0]    date_last;

  cal_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .halt       (stop_osc),
    .restart    (load_en),
    .sec_pulse  (sec_pulse),
    .test_phase (test_phase)
  );

  cal_month_len u_mlen (
    .month     (fval[F_MON]),
    .year      (fval[F_YEAR]),
    .last_date (date_last)
  );

  always_comb begin
    fhi[F_SEC]  = 8'h59;
    fhi[F_MIN]  = 8'h59;
    fhi[F_HOUR] = 8'h23;
    fhi[F_DOW]  = 8'h07;
    fhi[F_DATE] = date_last;
    fhi[F_MON]  = 8'h12;
    fhi[F_YEAR] = 8'h99;
    fhi[F_CENT] = 8'h39;
  end

  // Carry chain: hours feed both day of week and date.
  always_comb begin
    finc[F_SEC]  = sec_pulse;
    finc[F_MIN]  = fcarry[F_SEC];
    finc[F_HOUR] = fcarry[F_MIN];
    finc[F_DOW]  = fcarry[F_HOUR];
    finc[F_DATE] = fcarry[F_HOUR];
    finc[F_MON]  = fcarry[F_DATE];
    finc[F_YEAR] = fcarry[F_MON];
    finc[F_CENT] = fcarry[F_YEAR];
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    cal_bcd_field #(
      .LO  (FIELD_LO[8*i +: 8]),
      .RST (FIELD_RST[8*i +: 8])
    ) u_field (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (finc[i]),
      .load     (load_en),
      .load_val (ld_time[8*i +: 8]),
      .hi       (fhi[i]),
      .val      (fval[i]),
      .carry    (fcarry[i])
    );
  end

  assign sec_o   = {fval[F_SEC][7:1], fval[F_SEC][0] ^ (freq_test && !stop_osc && test_phase)};
  assign min_o   = fval[F_MIN];
  assign hour_o  = fval[F_HOUR];
  assign dow_o   = fval[F_DOW];
  assign date_o  = fval[F_DATE];
  assign month_o = fval[F_MON];
  assign year_o  = fval[F_YEAR];
  assign cent_o  = fval[F_CENT];

  // R9
  stop_holds_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_osc && !load_en) |=> ($stable(min_o) && $stable(hour_o) && $stable(dow_o) &&
                               $stable(date_o) && $stable(month_o) && $stable(year_o) &&
                               $stable(cent_o) && $stable(fval[F_SEC])));

  // R10
  no_test_true_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_test |-> (sec_o == fval[F_SEC]));

  // R4
  dow_and_date_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finc[F_DOW] != finc[F_DATE]) |-> 1'b0);

endmodule

// File: tb/bcd_calendar_counter_test.sv
`timescale 1ns/100ps
module bcd_calendar_counter_test;
  localparam int DIV = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        stop_osc = 1'b0;
  logic        freq_test = 1'b0;
  logic        load_en = 1'b0;
  logic [63:0] ld_time = '0;
  logic [7:0]  sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, cent_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit compare_on = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar_counter #(.PRESC_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stop_osc(stop_osc),
    .freq_test(freq_test), .load_en(load_en), .ld_time(ld_time),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .cent_o(cent_o)
  );

  // ---------------- behavioural reference model ----------------
  int m_f[8];   // decimal: sec, min, hour, dow, date, month, year, century
  int m_p;

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic bump(input int i, input int lo, input int hi, output bit wrapped);
    if (m_f[i] >= hi) begin m_f[i] = lo; wrapped = 1'b1; end
    else begin m_f[i] = m_f[i] + 1; wrapped = 1'b0; end
  endtask

  task automatic one_second();
    bit w;
    int dl;
    bump(0, 0, 59, w); if (!w) return;
    bump(1, 0, 59, w); if (!w) return;
    bump(2, 0, 23, w); if (!w) return;
    dl = days_in(m_f[5], m_f[6]);
    bump(3, 1, 7, w);
    bump(4, 1, dl, w); if (!w) return;
    bump(5, 1, 12, w); if (!w) return;
    bump(6, 0, 99, w); if (!w) return;
    bump(7, 0, 39, w);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_f = '{0, 0, 0, 1, 1, 1, 0, 20};
      m_p = 0;
    end else if (load_en) begin
      for (int i = 0; i < 8; i++) m_f[i] = from_bcd(ld_time[8*i +: 8]);
      m_p = 0;
    end else if (tick_en && !stop_osc) begin
      if (m_p == DIV - 1) begin m_p = 0; one_second(); end
      else m_p = m_p + 1;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input int act, input int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  function automatic int out_field(int i);
    case (i)
      0: return int'(sec_o);   1: return int'(min_o);
      2: return int'(hour_o);  3: return int'(dow_o);
      4: return int'(date_o);  5: return int'(month_o);
      6: return int'(year_o);  default: return int'(cent_o);
    endcase
  endfunction

  function automatic int exp_field(int i);
    int v;
    v = to_bcd(m_f[i]);
    if (i == 0 && freq_test && !stop_osc)
      v = v ^ ((m_p / (DIV / 1024)) % 2);
    return v;
  endfunction

  string field_tag[8] = '{"R3 sec", "R3 min", "R3 hour", "R4 dow", "R5 date",
                          "R7 month", "R7 year", "R7 century"};

  always @(negedge clk) begin
    cycles++;
    if (compare_on && rst_n) begin
      for (int i = 0; i < 8; i++) begin
        string t;
        t = (i == 0 && freq_test) ? "R10 sec lsb" : field_tag[i];
        chk(t, out_field(i), exp_field(i));
      end
    end
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive_step();
    @(posedge clk); #0.5;
  endtask

  task automatic run_ticks(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      tick_en = 1'b1; drive_step();
      if (gap > 0) begin
        tick_en = 1'b0;
        for (int g = 0; g < gap; g++) drive_step();
      end
    end
    tick_en = 1'b0;
  endtask

  task automatic do_load(input int cen, input int yr, input int mo, input int dt,
                         input int dw, input int hr, input int mi, input int se);
    ld_time = {8'(cen), 8'(yr), 8'(mo), 8'(dt), 8'(dw), 8'(hr), 8'(mi), 8'(se)};
    load_en = 1'b1; drive_step();
    load_en = 1'b0; drive_step();
  endtask

  task automatic settle();
    @(negedge clk); #0.1;
  endtask

  initial begin
    drive_step(); drive_step();
    rst_n = 1'b1;
    settle();
    // R1 reset state
    chk("R1 sec", sec_o, 'h00);   chk("R1 min", min_o, 'h00);
    chk("R1 hour", hour_o, 'h00); chk("R1 dow", dow_o, 'h01);
    chk("R1 date", date_o, 'h01); chk("R1 month", month_o, 'h01);
    chk("R1 year", year_o, 'h00); chk("R1 cent", cent_o, 'h20);
    compare_on = 1'b1;
    drive_step();

    // R2 exact period: DIV-1 pulses no change, one more advances
    run_ticks(DIV - 1, 0); settle();
    chk("R2 before period", sec_o, 'h00);
    drive_step(); run_ticks(1, 0); settle();
    chk("R2 after period", sec_o, 'h01);
    drive_step();
    // R2 gapped ticks
    run_ticks(DIV, 2); settle();
    chk("R2 gapped", sec_o, 'h02);
    drive_step();

    // R3 R4 R7 full ripple to new century
    do_load('h20, 'h99, 'h12, 'h31, 'h07, 'h23, 'h59, 'h59);
    run_ticks(DIV, 0); settle();
    chk("R3 hour wrap", hour_o, 'h00); chk("R3 min wrap", min_o, 'h00);
    chk("R4 dow 07->01", dow_o, 'h01); chk("R7 month wrap", month_o, 'h01);
    chk("R7 year wrap", year_o, 'h00); chk("R7 century inc", cent_o, 'h21);
    drive_step();

    // R5 thirty-day month
    do_load('h20, 'h23, 'h04, 'h30, 'h03, 'h23, 'h59, 'h59);
    run_ticks(DIV, 0); settle();
    chk("R5 april end date", date_o, 'h01); chk("R5 april end month", month_o, 'h05);
    drive_step();
    // R5 31-day month does not wrap at 30
    do_load('h20, 'h23, 'h08, 'h30, 'h03, 'h23, 'h59, 'h59);
    run_ticks(DIV, 0); settle();
    chk("R5 august 31", date_o, 'h31);
    drive_step();

    // R6 leap and non-leap Februaries
    do_load('h20, 'h24, 'h02, 'h28, 'h03, 'h23, 'h59, 'h59);
    run_ticks(DIV, 0); settle();
    chk("R6 leap 24 feb 29", date_o, 'h29);
    drive_step();
    do_load('h20, 'h12, 'h02, 'h29, 'h03, 'h23, 'h59, 'h59);
    run_ticks(DIV, 0); settle();
    chk("R6 leap 12 march", month_o, 'h03); chk("R6 leap 12 date", date_o, 'h01);
    drive_step();
    do_load('h20, 'h10, 'h02, 'h28, 'h03, 'h23, 'h59, 'h59);
    run_ticks(DIV, 0); settle();
    chk("R6 year 10 not leap", month_o, 'h03);
    drive_step();

    // R7 century 39 -> 00
    do_load('h39, 'h99, 'h12, 'h31, 'h02, 'h23, 'h59, 'h59);
    run_ticks(DIV, 0); settle();
    chk("R7 century wrap", cent_o, 'h00);
    drive_step();

    // R8 load restarts prescaler mid-count
    run_ticks(500, 0);
    do_load('h20, 'h50, 'h06, 'h15, 'h05, 'h10, 'h20, 'h30);
    run_ticks(DIV - 1, 0); settle();
    chk("R8 restart no early advance", sec_o, 'h30);
    drive_step(); run_ticks(1, 0); settle();
    chk("R8 advance after full period", sec_o, 'h31);
    drive_step();

    // R9 stop ignores ticks
    stop_osc = 1'b1; drive_step();
    run_ticks(2 * DIV, 0); settle();
    chk("R9 stopped sec", sec_o, 'h31); chk("R9 stopped min", min_o, 'h20);
    drive_step();
    // R8 load works while stopped
    do_load('h20, 'h01, 'h01, 'h01, 'h01, 'h00, 'h00, 'h05);
    settle();
    chk("R8 load while stopped", sec_o, 'h05);
    drive_step();

    // R10 frequency test: no toggle while stopped, toggles while running
    freq_test = 1'b1; tick_en = 1'b1; drive_step(); settle();
    begin
      int a;
      a = sec_o[0];
      drive_step(); settle();
      chk("R10 no toggle when stopped", sec_o[0], a);
      stop_osc = 1'b0; drive_step(); settle();
      a = sec_o[0];
      drive_step(); settle();
      chk("R10 toggles each tick", sec_o[0], a ^ 1);
      chk("R10 upper bits intact", sec_o[7:1], 'h05 >> 1);
    end
    drive_step();
    tick_en = 1'b0; freq_test = 1'b0; drive_step();

    // R11 out-of-range date rolls over
    do_load('h20, 'h23, 'h04, 'h31, 'h03, 'h23, 'h59, 'h59);
    run_ticks(DIV, 0); settle();
    chk("R11 date 31 in april", date_o, 'h01); chk("R11 month carry", month_o, 'h05);
    drive_step();

    compare_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule